// File: doc/BRIEF.md
# Boundary-Scan Instruction and Data Register Unit

This block sits behind a test access port sequencer and handles everything between the serial test data input and output. It keeps a 4-bit instruction register and decodes it to pick one of three data registers. The first is a boundary chain of parameterised length that samples a vector of pin values and copies its contents into a bank of update latches. The second is a one-bit core reset register whose value drives a reset request line. The third is a one-bit bypass register. The sequencer elsewhere supplies one strobe per active state: capture, shift and update for the instruction path and for the data path. It also supplies a synchronous reset that is high while the sequencer sits in its test-logic-reset state.

All shift, capture and update actions happen on the rising edge of the test clock. The serial output is registered on the falling edge, so the bit that the next rising edge shifts out is already on the line before that edge. The update latches are a plain output vector and drive no pin. The reset request comes straight from the one-bit shift stage, with no update stage in between. Loading the reset instruction leaves the instruction register and the sequencer untouched, so the request can be raised and then dropped with further data scans.

Top module: `jtag_ir_dr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the instruction register becomes 0xF (bypass), the reset request and every update latch clear, and `tdo` is 0 from the next falling edge.
- R2: A rising edge with `ir_capture` loads 4'b0001 into the instruction shift stage. Each rising edge with `ir_shift` moves that stage one place toward bit 0, with `tdi` entering bit 3, and bit 0 is shown on `tdo`. A rising edge with `ir_update` makes the shifted value the active instruction.
- R3: Active instruction 0x2 selects the boundary chain, 0xC selects the reset register, and every other code, 0xF included, selects the bypass register.
- R4: With the chain selected, a rising edge with `dr_capture` loads `pin_sample` into the chain. Chain bit 0 is the first bit out.
- R5: With the chain selected, each rising edge with `dr_shift` moves the chain one place toward bit 0, with `tdi` entering bit CHAIN_LEN-1.
- R6: A rising edge with `dr_update` while the chain is selected copies the chain into `upd_latch`. No other condition changes `upd_latch` except `rst`.
- R7: With the reset register selected, each rising edge with `dr_shift` stores `tdi` in it, and `core_reset_req` equals that stored bit at once. Capture and update strobes leave it unchanged.
- R8: The active instruction changes only on `ir_update` or `rst`. A raised reset request does not disturb it.
- R9: With bypass selected, `dr_capture` loads 0 and each `dr_shift` edge stores `tdi`, which gives a one-bit delay from `tdi` to `tdo`.
- R10: `tdo` is updated on the falling edge of `tck`. During `ir_shift` it shows instruction stage bit 0, during `dr_shift` it shows bit 0 of the selected data register, and otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, high in test-logic-reset |
| tdi | input | 1 | Serial test data in |
| ir_capture | input | 1 | Instruction capture state strobe |
| ir_shift | input | 1 | Instruction shift state strobe |
| ir_update | input | 1 | Instruction update state strobe |
| dr_capture | input | 1 | Data capture state strobe |
| dr_shift | input | 1 | Data shift state strobe |
| dr_update | input | 1 | Data update state strobe |
| pin_sample | input | CHAIN_LEN | Pin values sampled by the chain |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| upd_latch | output | CHAIN_LEN | Chain update latches, not connected to pins |
| core_reset_req | output | 1 | Core reset request from the reset register |

## Verification
The chain is run with a captured pin pattern that differs from the pattern shifted in. This shows that capture, shift order and the copy into the latches each move the correct bits. A second scan without a capture proves that the shifted-in data stayed in the chain. Each selection is then tried with the same two-bit input pattern. A captured zero followed by one delay cell separates bypass from the reset register, and an unrecognised code 0x5 is also tried. The reset register is raised, driven through capture and update strobes to show that the request does not move, and then cleared by a second scan whose first output bit still shows the old 1. That last scan proves the instruction survived the request.

// File: rtl/jtag_unit_pkg.sv
package jtag_unit_pkg;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'h2;
  localparam logic [IR_W-1:0] OP_CORE_RST = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'hF;
  localparam logic [IR_W-1:0] IR_CAP_PAT  = 4'b0001;

  typedef enum logic [1:0] {
    SEL_BSCAN  = 2'd0,
    SEL_RSTREG = 2'd1,
    SEL_BYPASS = 2'd2
  } dr_sel_e;
endpackage

// File: rtl/jtag_instr_reg.sv
module jtag_instr_reg
  import jtag_unit_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  logic            cap,
  input  logic            shf,
  input  logic            upd,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q,
  output dr_sel_e         dr_sel
);
  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sr <= IR_CAP_PAT;
      ir_q  <= OP_BYPASS;
    end else begin
      if (cap)      ir_sr <= IR_CAP_PAT;
      else if (shf) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (upd)      ir_q  <= ir_sr;
    end
  end

  always_comb begin
    unique case (ir_q)
      OP_SAMPLE:   dr_sel = SEL_BSCAN;
      OP_CORE_RST: dr_sel = SEL_RSTREG;
      default:     dr_sel = SEL_BYPASS;
    endcase
  end
endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 tck,
  input  logic                 rst,
  input  logic                 tdi,
  input  logic                 en,
  input  logic                 cap,
  input  logic                 shf,
  input  logic                 upd,
  input  logic [CHAIN_LEN-1:0] pin_sample,
  output logic [CHAIN_LEN-1:0] chain_q,
  output logic [CHAIN_LEN-1:0] upd_latch
);
  localparam int LAST = CHAIN_LEN - 1;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic serial_in;
    if (i == LAST) begin : g_head
      assign serial_in = tdi;
    end else begin : g_body
      assign serial_in = chain_q[i+1];
    end

    always_ff @(posedge tck) begin
      if (rst) begin
        chain_q[i]   <= 1'b0;
        upd_latch[i] <= 1'b0;
      end else if (en) begin
        if (cap)      chain_q[i] <= pin_sample[i];
        else if (shf) chain_q[i] <= serial_in;
        if (upd)      upd_latch[i] <= chain_q[i];
      end
    end
  end
endmodule

// File: rtl/jtag_single_bit_drs.sv
module jtag_single_bit_drs
  import jtag_unit_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tdi,
  input  dr_sel_e sel,
  input  logic    cap,
  input  logic    shf,
  output logic    rst_bit,
  output logic    byp_bit
);
  always_ff @(posedge tck) begin
    if (rst) begin
      rst_bit <= 1'b0;
      byp_bit <= 1'b0;
    end else begin
      if (sel == SEL_RSTREG && shf) rst_bit <= tdi;
      if (sel == SEL_BYPASS) begin
        if (cap)      byp_bit <= 1'b0;
        else if (shf) byp_bit <= tdi;
      end
    end
  end
endmodule

// File: rtl/jtag_ir_dr_unit.sv
module jtag_ir_dr_unit
  import jtag_unit_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 tck,
  input  logic                 rst,
  input  logic                 tdi,
  input  logic                 ir_capture,
  input  logic                 ir_shift,
  input  logic                 ir_update,
  input  logic                 dr_capture,
  input  logic                 dr_shift,
  input  logic                 dr_update,
  input  logic [CHAIN_LEN-1:0] pin_sample,
  output logic                 tdo,
  output logic [CHAIN_LEN-1:0] upd_latch,
  output logic                 core_reset_req
);
  logic [IR_W-1:0]      ir_sr;
  logic [IR_W-1:0]      ir_q;
  dr_sel_e              dr_sel;
  logic [CHAIN_LEN-1:0] chain_q;
  logic                 byp_bit;
  logic                 chain_en;

  assign chain_en = (dr_sel == SEL_BSCAN);

  jtag_instr_reg u_ir (
    .tck(tck), .rst(rst), .tdi(tdi),
    .cap(ir_capture), .shf(ir_shift), .upd(ir_update),
    .ir_sr(ir_sr), .ir_q(ir_q), .dr_sel(dr_sel)
  );

  jtag_bscan_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
    .tck(tck), .rst(rst), .tdi(tdi), .en(chain_en),
    .cap(dr_capture), .shf(dr_shift), .upd(dr_update),
    .pin_sample(pin_sample), .chain_q(chain_q), .upd_latch(upd_latch)
  );

  jtag_single_bit_drs u_bits (
    .tck(tck), .rst(rst), .tdi(tdi), .sel(dr_sel),
    .cap(dr_capture), .shf(dr_shift),
    .rst_bit(core_reset_req), .byp_bit(byp_bit)
  );

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo <= 1'b0;
    end else if (ir_shift) begin
      tdo <= ir_sr[0];
    end else if (dr_shift) begin
      unique case (dr_sel)
        SEL_BSCAN:  tdo <= chain_q[0];
        SEL_RSTREG: tdo <= core_reset_req;
        default:    tdo <= byp_bit;
      endcase
    end else begin
      tdo <= 1'b0;
    end
  end
endmodule

// File: rtl/jtag_ir_dr_unit_chk.sv
module jtag_ir_dr_unit_chk
  import jtag_unit_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input logic                 tck,
  input logic                 rst,
  input logic                 tdi,
  input logic                 ir_capture,
  input logic                 ir_update,
  input logic                 dr_capture,
  input logic                 dr_shift,
  input logic                 dr_update,
  input logic [CHAIN_LEN-1:0] pin_sample,
  input logic [CHAIN_LEN-1:0] upd_latch,
  input logic                 core_reset_req,
  input logic [IR_W-1:0]      ir_sr,
  input logic [IR_W-1:0]      ir_q,
  input logic [CHAIN_LEN-1:0] chain_q
);
  AST_RST_LOADS_BYPASS: assert property (@(posedge tck)
    rst |=> (ir_q == OP_BYPASS && !core_reset_req && upd_latch == '0)); // R1
  AST_IR_CAPTURE_PAT: assert property (@(posedge tck) disable iff (rst)
    ir_capture |=> ir_sr == IR_CAP_PAT); // R2
  AST_IR_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (rst)
    !ir_update |=> $stable(ir_q)); // R8
  AST_PIN_CAPTURE: assert property (@(posedge tck) disable iff (rst)
    (dr_capture && ir_q == OP_SAMPLE) |=> chain_q == $past(pin_sample)); // R4
  AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (rst)
    !(dr_update && ir_q == OP_SAMPLE) |=> $stable(upd_latch)); // R6
  AST_RSTREG_TAKES_TDI: assert property (@(posedge tck) disable iff (rst)
    (dr_shift && ir_q == OP_CORE_RST) |=> core_reset_req == $past(tdi)); // R7
  AST_RSTREG_HOLD: assert property (@(posedge tck) disable iff (rst)
    !(dr_shift && ir_q == OP_CORE_RST) |=> $stable(core_reset_req)); // R7
endmodule

bind jtag_ir_dr_unit jtag_ir_dr_unit_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (.*);

// File: tb/jtag_ir_dr_unit_bench.sv
module jtag_ir_dr_unit_bench;
  localparam int  N = 8;
  localparam time TCK_PERIOD = 10;

  logic tck = 1'b0, rst = 1'b1, tdi = 1'b0;
  logic ir_capture = 0, ir_shift = 0, ir_update = 0;
  logic dr_capture = 0, dr_shift = 0, dr_update = 0;
  logic [N-1:0] pin_sample = '0;
  logic tdo, core_reset_req;
  logic [N-1:0] upd_latch;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_ir = 4'hF, m_irsr = 4'b0001;
  bit         m_chain[$];
  logic [N-1:0] m_latch = '0;
  logic m_rr = 0, m_byp = 0, m_tdo = 0;

  jtag_ir_dr_unit #(.CHAIN_LEN(N)) u_jtag_ir_dr_unit (.*);

  always #(TCK_PERIOD/2) tck = ~tck;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int sel_of(logic [3:0] op);
    if (op == 4'h2) return 0;
    if (op == 4'hC) return 1;
    return 2;
  endfunction

  task automatic model_neg();
    if (rst) m_tdo = 0;
    else if (ir_shift) m_tdo = m_irsr[0];
    else if (dr_shift) begin
      case (sel_of(m_ir))
        0: m_tdo = m_chain[0];
        1: m_tdo = m_rr;
        default: m_tdo = m_byp;
      endcase
    end else m_tdo = 0;
  endtask

  task automatic model_pos();
    int s = sel_of(m_ir);
    if (rst) begin
      m_ir = 4'hF; m_irsr = 4'b0001; m_latch = '0; m_rr = 0; m_byp = 0;
      foreach (m_chain[i]) m_chain[i] = 0;
    end else begin
      if (ir_capture) m_irsr = 4'b0001;
      else if (ir_shift) m_irsr = {tdi, m_irsr[3:1]};
      if (ir_update) m_ir = m_irsr;
      if (s == 0) begin
        if (dr_capture) foreach (m_chain[i]) m_chain[i] = pin_sample[i];
        else if (dr_shift) begin
          void'(m_chain.pop_front());
          m_chain.push_back(tdi);
        end
        if (dr_update) foreach (m_chain[i]) m_latch[i] = m_chain[i];
      end else if (s == 1) begin
        if (dr_shift) m_rr = tdi;
      end else begin
        if (dr_capture) m_byp = 0;
        else if (dr_shift) m_byp = tdi;
      end
    end
  endtask

  // one clock: inputs held from just after a rising edge to just after the next
  task automatic step(bit ic, bit is, bit iu, bit dc, bit ds, bit du, logic d);
    ir_capture = ic; ir_shift = is; ir_update = iu;
    dr_capture = dc; dr_shift = ds; dr_update = du; tdi = d;
    @(negedge tck); #1;
    model_neg();
    chk("R10 tdo", tdo, m_tdo);
    @(posedge tck); #1;
    model_pos();
    chk("R6 upd_latch", upd_latch, m_latch);
    chk("R7 core_reset_req", core_reset_req, m_rr);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load_ir(logic [3:0] v, output logic [3:0] seen);
    step(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 0, 0, 0, 0, v[i]);
      seen[i] = tdo;
    end
    step(0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic scan_dr(bit do_cap, int n, logic [63:0] d, bit do_upd,
                         output logic [63:0] seen);
    seen = '0;
    if (do_cap) step(0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 1, 0, d[i]);
      seen[i] = tdo;
    end
    if (do_upd) step(0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #(TCK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  irs;
    logic [63:0] seen;
    for (int i = 0; i < N; i++) m_chain.push_back(0);
    @(posedge tck); #1;
    rst = 1; idle(); idle();
    rst = 0; idle();
    chk("R1 tdo after reset", tdo, 0);
    chk("R1 latch after reset", upd_latch, 0);
    chk("R1 reset req after reset", core_reset_req, 0);

    // reset instruction is bypass: captured 0 then one-bit delay
    scan_dr(1, 2, 64'b11, 1, seen);
    chk("R9 bypass after reset", seen[1:0], 2'b10);

    // instruction capture pattern and boundary scan
    load_ir(4'h2, irs);
    chk("R2 ir capture pattern", irs, 4'b0001);
    pin_sample = 8'hA5;
    scan_dr(1, N, 64'h3C, 1, seen);
    chk("R4 captured pins out", seen[N-1:0], 8'hA5);
    chk("R6 latch after update", upd_latch, 8'h3C);
    pin_sample = 8'h0F;
    scan_dr(0, N, 64'h00, 0, seen);
    chk("R5 chain held shifted data", seen[N-1:0], 8'h3C);
    chk("R6 latch unchanged without update", upd_latch, 8'h3C);

    // bypass update does not touch latches
    load_ir(4'hF, irs);
    chk("R2 ir shift-out is capture pattern", irs, 4'b0001);
    scan_dr(1, 3, 64'b101, 1, seen);
    chk("R9 bypass delay", seen[2:0], 3'b010);
    chk("R6 latch kept under bypass", upd_latch, 8'h3C);

    // core reset register
    load_ir(4'hC, irs);
    scan_dr(1, 1, 64'b1, 1, seen);
    chk("R7 reset req raised", core_reset_req, 1);
    scan_dr(1, 0, 64'b0, 1, seen);
    idle();
    chk("R7 reset req held through capture/update", core_reset_req, 1);
    scan_dr(0, 1, 64'b0, 0, seen);
    chk("R8 instruction kept under reset req", seen[0], 1);
    chk("R7 reset req dropped", core_reset_req, 0);
    scan_dr(0, 1, 64'b1, 0, seen);
    chk("R7 reset req raised again", core_reset_req, 1);

    // unrecognised code acts as bypass
    load_ir(4'h5, irs);
    chk("R3 reset req kept across ir load", core_reset_req, 1);
    scan_dr(1, 2, 64'b11, 0, seen);
    chk("R3 code 5 is bypass", seen[1:0], 2'b10);
    idle();
    chk("R10 tdo low outside shift", tdo, 0);

    // mid-run reset
    load_ir(4'h2, irs);
    rst = 1; idle();
    rst = 0; idle();
    chk("R1 reset req cleared", core_reset_req, 0);
    chk("R1 latch cleared", upd_latch, 0);
    scan_dr(1, 2, 64'b11, 0, seen);
    chk("R1 ir back to bypass", seen[1:0], 2'b10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule